// File: doc/BRIEF.md
# Multicycle Accumulator CPU Core

This block is a small stored-program processor with one working register, the accumulator. It shares one memory port between instruction fetch and data access. Every address it sends out is first held in a memory address register, and every word it reads or writes passes through a memory buffer register. As a result, each memory transaction is a sequence of separate register-transfer steps.

An instruction word is 16 bits wide. The upper four bits select the operation and the lower twelve bits give an address or an immediate value. The core can load, store, add a memory word, or add an immediate. All other operation codes do nothing. The program counter starts at a parameterised address, so a test program can sit anywhere in the 4096-word space. The accumulator, program counter and instruction register are brought out so a surrounding bench or debug fabric can watch progress.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the core sets `pc_q` to `PC_RESET` and clears `acc_q`, `ir_q`, the address register and the buffer register. It also holds `mem_rd` and `mem_wr` low.
- R2: Fetching one instruction works as follows. The address register takes `pc_q`, and `mem_rd` goes high for one cycle with `mem_addr` equal to that address. The returned word moves through the buffer register into `ir_q`. `pc_q` then rises by exactly one, wrapping at 12 bits, before the instruction executes. `pc_q` never changes in any other way.
- R3: In an instruction word, bits 15:12 are the operation code and bits 11:0 are the operand.
- R4: Code 0 (load) reads the word at the operand address and copies it into `acc_q`.
- R5: Code 1 (store) raises `mem_wr` for exactly one cycle. In that cycle `mem_addr` equals the operand and `mem_wdata` equals `acc_q`.
- R6: Code 2 (add) reads the word at the operand address and adds it to `acc_q`, modulo 2^16.
- R7: Code 3 (add immediate) zero-extends the operand to 16 bits and adds it to `acc_q`, modulo 2^16. It performs no data read.
- R8: Codes 4 to 15 leave `acc_q` and memory unchanged and make no data access, but `pc_q` still advances.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle. Read data is taken from `mem_rdata` one cycle after the cycle in which `mem_rd` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Store data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |

## Verification
Some properties are checked on every cycle by the assertions:
- the two strobes are mutually exclusive;
- a write pulse lasts a single cycle and carries the accumulator value;
- the program counter moves only by single increments;
- an immediate add never issues a data read.

The arithmetic results are covered by the bench scenarios. These include the load, add and wrap values, the untouched accumulator after undefined codes, the memory image left by stores, and the total number of read and write strobes. The bench compares them against an instruction-level model, using random programs and a directed worked example.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = WORD_W - OPC_W;
    localparam int PAD_W  = WORD_W - ADDR_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 4'h3;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] arg;
    } instr_t;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_RD, ST_F_LAT, ST_F_IR, ST_DEC,
        ST_O_RD, ST_O_LAT, ST_EXEC, ST_S_MBR, ST_S_WR
    } state_e;

    typedef enum logic [1:0] {
        ACC_HOLD, ACC_TAKE_MBR, ACC_SUM_MBR, ACC_SUM_IMM
    } acc_op_e;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_ir;
        logic    mbr_from_mem;
        logic    mbr_from_acc;
        logic    ir_load;
        logic    pc_inc;
        acc_op_e acc_op;
        logic    mem_rd;
        logic    mem_wr;
    } ctl_t;

    function automatic logic [WORD_W-1:0] zext_arg(input logic [ADDR_W-1:0] a);
        return {{PAD_W{1'b0}}, a};
    endfunction
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opc,
    output ctl_t             ctl
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_F_MAR;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        unique case (state_q)
            ST_F_MAR: begin ctl.mar_from_pc  = 1'b1; state_d = ST_F_RD;  end
            ST_F_RD:  begin ctl.mem_rd       = 1'b1; state_d = ST_F_LAT; end
            ST_F_LAT: begin ctl.mbr_from_mem = 1'b1; state_d = ST_F_IR;  end
            ST_F_IR: begin
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
                state_d     = ST_DEC;
            end
            ST_DEC: begin
                ctl.mar_from_ir = 1'b1;
                if (opc == OPC_LOAD || opc == OPC_ADD) begin
                    state_d = ST_O_RD;
                end else if (opc == OPC_STORE) begin
                    state_d = ST_S_MBR;
                end else if (opc == OPC_ADDI) begin
                    ctl.acc_op = ACC_SUM_IMM;
                    state_d    = ST_F_MAR;
                end else begin
                    state_d = ST_F_MAR;
                end
            end
            ST_O_RD:  begin ctl.mem_rd       = 1'b1; state_d = ST_O_LAT; end
            ST_O_LAT: begin ctl.mbr_from_mem = 1'b1; state_d = ST_EXEC;  end
            ST_EXEC: begin
                ctl.acc_op = (opc == OPC_LOAD) ? ACC_TAKE_MBR : ACC_SUM_MBR;
                state_d    = ST_F_MAR;
            end
            ST_S_MBR: begin ctl.mbr_from_acc = 1'b1; state_d = ST_S_WR;  end
            ST_S_WR:  begin ctl.mem_wr       = 1'b1; state_d = ST_F_MAR; end
            default:  state_d = ST_F_MAR;
        endcase
    end

    // R7: an immediate add goes straight back to fetch with no data read
    assert_addi_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEC && opc == OPC_ADDI) |=> (state_q == ST_F_MAR && !ctl.mem_rd));
    // R9: strobes never overlap
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_rd && ctl.mem_wr));
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar_q,
    output logic [WORD_W-1:0] mbr_q,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output instr_t            ir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mbr_q <= '0;
            acc_q <= '0;
            ir_q  <= '0;
            pc_q  <= PC_RESET;
        end else begin
            if (ctl.mar_from_pc)      mar_q <= pc_q;
            else if (ctl.mar_from_ir) mar_q <= ir_q.arg;

            if (ctl.mbr_from_mem)      mbr_q <= mem_rdata;
            else if (ctl.mbr_from_acc) mbr_q <= acc_q;

            if (ctl.ir_load) ir_q <= instr_t'(mbr_q);
            if (ctl.pc_inc)  pc_q <= pc_q + ADDR_W'(1);

            unique case (ctl.acc_op)
                ACC_TAKE_MBR: acc_q <= mbr_q;
                ACC_SUM_MBR:  acc_q <= acc_q + mbr_q;
                ACC_SUM_IMM:  acc_q <= acc_q + zext_arg(ir_q.arg);
                default:      acc_q <= acc_q;
            endcase
        end
    end

    // R2: the program counter only ever steps by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + ADDR_W'(1)));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [WORD_W-1:0] ir_q
);
    ctl_t   ctl;
    instr_t ir_s;

    acc_cpu_ctrl u_ctrl (
        .clk (clk),
        .rst (rst),
        .opc (ir_s.opc),
        .ctl (ctl)
    );

    acc_cpu_dpath #(.PC_RESET(PC_RESET)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar_q     (mem_addr),
        .mbr_q     (mem_wdata),
        .acc_q     (acc_q),
        .pc_q      (pc_q),
        .ir_q      (ir_s)
    );

    assign ir_q   = ir_s;
    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;

    // R5: a write pulse lasts one cycle
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);
    // R5: store data on the bus equals the accumulator
    assert_wr_data_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == acc_q));
endmodule

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
    localparam logic [11:0] START = 12'h100;
    localparam int          NPROG = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] acc_q;
    logic [11:0] pc_q;
    logic [15:0] ir_q;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int exp_rd = 0, exp_wr = 0;
    bit hung = 1'b0;

    logic [15:0] mem   [0:4095];
    logic [15:0] m_mem [0:4095];
    logic [15:0] prog  [0:NPROG-1];
    logic [15:0] m_acc;

    always #4 clk = ~clk;

    acc_cpu #(.PC_RESET(START)) uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .acc_q(acc_q), .pc_q(pc_q), .ir_q(ir_q)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] = mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) rd_cnt++;
            if (mem_wr) wr_cnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // instruction-level reference model
    function automatic string model_exec(input logic [15:0] w);
        logic [3:0]  op  = w[15:12];
        logic [11:0] arg = w[11:0];
        exp_rd++;
        case (op)
            4'h0: begin m_acc = m_mem[arg]; exp_rd++; return "R4"; end
            4'h1: begin m_mem[arg] = m_acc; exp_wr++; return "R5"; end
            4'h2: begin m_acc = m_acc + m_mem[arg]; exp_rd++; return "R6"; end
            4'h3: begin m_acc = m_acc + {4'h0, arg}; return "R7"; end
            default: return "R8";
        endcase
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 16'hF000;
            m_mem[i] = 16'hF000;
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] v);
        mem[a] = v;
        m_mem[a] = v;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; exp_rd = 0; exp_wr = 0; m_acc = '0;
        rst = 1'b0;
    endtask

    task automatic wait_pc(input logic [11:0] tgt);
        int cyc = 0;
        while (pc_q !== tgt && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        if (pc_q !== tgt) hung = 1'b1;
    endtask

    task automatic run(input int n, input string name);
        string tag;
        do_reset();
        for (int k = 1; k <= n; k++) begin
            wait_pc(START + 12'(k + 1));
            tag = model_exec(prog[k-1]);
            check({tag, " acc ", name}, {16'h0, acc_q}, {16'h0, m_acc});
            check({"R2 ir ", name}, {16'h0, ir_q},
                  {16'h0, (k < n) ? prog[k] : 16'hF000});
        end
        exp_rd++;
        check({"R2 read count ", name}, rd_cnt, exp_rd);
        check({"R5 write count ", name}, wr_cnt, exp_wr);
        begin
            int bad = 0;
            for (int a = 12'h200; a < 12'h300; a++)
                if (mem[a] !== m_mem[a]) bad++;
            check({"R5 memory image ", name}, bad, 0);
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_mem();
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc", {20'h0, pc_q}, {20'h0, START});
        check("R1 acc", {16'h0, acc_q}, 32'h0);
        check("R1 ir", {16'h0, ir_q}, 32'h0);
        check("R1 addr", {20'h0, mem_addr}, 32'h0);
        check("R1 strobes", {30'h0, mem_rd, mem_wr}, 32'h0);

        // worked example: B = B + A; C = B + 2  (R3 field split)
        clear_mem();
        put(12'h200, 16'd5); put(12'h201, 16'd3); put(12'h202, 16'd0);
        prog[0] = 16'h0200; prog[1] = 16'h2201; prog[2] = 16'h1201;
        prog[3] = 16'h3002; prog[4] = 16'h1202;
        for (int i = 0; i < 5; i++) put(START + 12'(i), prog[i]);
        run(5, "example");
        check("R3 B result", {16'h0, mem[12'h201]}, 32'd8);
        check("R3 C result", {16'h0, mem[12'h202]}, 32'd10);
        if (hung) n_fail++;

        // wrap and undefined codes
        clear_mem();
        put(12'h200, 16'hFFFF); put(12'h201, 16'h8001);
        prog[0] = 16'h0200; prog[1] = 16'h3001; prog[2] = 16'hF123;
        prog[3] = 16'h4200; prog[4] = 16'h1201; prog[5] = 16'h0200;
        prog[6] = 16'h2200; prog[7] = 16'h3FFF; prog[8] = 16'h7201;
        for (int i = 0; i < 9; i++) put(START + 12'(i), prog[i]);
        run(9, "wrap");
        check("R6 wrap acc", {16'h0, acc_q}, 32'h0000_0FFD);
        check("R8 mem untouched", {16'h0, mem[12'h201]}, 32'h0);

        // random programs
        for (int r = 0; r < 3; r++) begin
            clear_mem();
            for (int a = 0; a < 32; a++) put(12'h200 + 12'(a), 16'($urandom));
            for (int i = 0; i < NPROG; i++) begin
                logic [3:0] op = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
                logic [11:0] arg = (op == 4'h3) ? 12'($urandom) : 12'h200 + 12'($urandom % 32);
                prog[i] = {op, arg};
                put(START + 12'(i), prog[i]);
            end
            run(NPROG, "random");
        end
        if (hung) begin
            n_chk++; n_fail++;
            $display("FAIL R2 pc did not advance actual=stalled expected=advancing");
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule